// File: doc/BRIEF.md
# Load-Reserve Reservation Monitor

This block keeps the single reservation that a load-and-reserve operation sets up, and decides whether a later store-conditional may complete. Each cycle the load/store unit presents an operation class, the effective address, whether the storage is cacheable and whether the access missed the cache. The block answers one cycle later with an alignment fault request, a store-conditional completion strobe with its pass/fail flag, and the request and reservation attribute for any resulting bus access.

Outside activity reaches the reservation in only two ways. The first is a pair of active-low cancel inputs driven by off-chip logic. The second is a snoop port on the internal bus, which reports writes made by the on-chip communication master. External bus traffic is not snooped. The reservation is a valid flag plus a word address, so bits 1:0 of every address are ignored when addresses are compared.

Top module: `resv_monitor`

## Requirements
- R1: A load-reserve (class 2) or store-conditional (class 3) with effAddr[1:0] not zero gives alignFault=1 in the next cycle, with scDone=0 and busReq=0, and leaves the reservation as it was.
- R2: An aligned load-reserve sets the reservation to its word address (effAddr above bit 1). A newer load-reserve replaces any older reservation.
- R3: An aligned store-conditional gives scDone=1 in the next cycle. scSuccess=1 is given only when the reservation is valid and its word address equals the store's word address.
- R4: Every aligned store-conditional clears the reservation, whether it passes or fails.
- R5: When either cancelAN or cancelBN is low in a cycle, the reservation is cleared.
- R6: A snoop with snoopValid, snoopWrite and snoopFromComm all high, whose snoopWord equals the reserved word, clears the reservation. Reads, writes from other masters and writes to other words leave it intact.
- R7: When a cancel or a snoop hit falls in the same cycle as an aligned load-reserve, the new reservation is kept. When it falls in the same cycle as a store-conditional, the store fails.
- R8: A non-faulting operation of class 1, 2 or 3 gives busReq=1 in the next cycle when it is cache-inhibited (cacheable=0) or misses the cache. busResvAttr=1 only for load-reserve or store-conditional to cache-inhibited storage. A cacheable reservation access that misses goes out with busResvAttr=0.
- R9: A synchronous reset (rst high) clears the reservation and holds all outputs at 0 in the cycle after.
- R10: Plain accesses (class 1) and idle cycles (class 0) never raise alignFault or scDone, whatever their alignment, and do not change the reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opClass | input | 2 | 0 idle, 1 plain access, 2 load-reserve, 3 store-conditional |
| effAddr | input | ADDR_W | Effective address of the operation |
| cacheable | input | 1 | Storage may be cached |
| cacheMiss | input | 1 | Access missed the cache |
| cancelAN | input | 1 | External reservation cancel A, active low |
| cancelBN | input | 1 | External reservation cancel B, active low |
| snoopValid | input | 1 | Internal-bus snoop cycle present |
| snoopWrite | input | 1 | Snooped cycle is a write |
| snoopFromComm | input | 1 | Snooped cycle comes from the communication master |
| snoopWord | input | ADDR_W-2 | Word address of the snooped cycle |
| alignFault | output | 1 | Alignment fault request |
| scDone | output | 1 | A store-conditional completed this cycle |
| scSuccess | output | 1 | The completed store-conditional passed |
| busReq | output | 1 | Operation goes to the bus |
| busResvAttr | output | 1 | Reservation attribute of that bus access |

## Verification
Every output is registered, so each result is due exactly one clock edge after the operation, cancel or snoop that caused it. A change to the reservation itself is seen only through the scSuccess of a later store-conditional. The driver applies one stimulus per cycle on the falling edge and queues the expected output set. The monitor takes one entry just after each following rising edge, so each queued entry is compared with the cycle in which its result is due. Same-cycle collisions between a cancel or snoop and a reservation operation are driven in one stimulus. The bench then probes the reservation on the next cycle.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PLAIN = 2'd1,
    OP_LRES  = 2'd2,
    OP_SCOND = 2'd3
  } opClass_e;

  // Strobes from control to the datapath
  typedef struct packed {
    logic loadResv;   // aligned load-reserve: capture the reservation
    logic scTry;      // aligned store-conditional: evaluate, then clear
    logic alignErr;   // misaligned reservation operation
    logic extCancel;  // one of the external cancel inputs is asserted
    logic busReq;     // operation reaches the bus
    logic busAttr;    // bus access carries the reservation attribute
  } ctrlStrobe_t;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  opClass_e    opClass,
  input  logic [1:0]  addrLow,
  input  logic        cacheable,
  input  logic        cacheMiss,
  input  logic        cancelAN,
  input  logic        cancelBN,
  output ctrlStrobe_t strobes
);

  logic isResvOp;
  logic misaligned;
  logic faultNow;
  logic toBus;

  always_comb begin
    isResvOp   = (opClass == OP_LRES) || (opClass == OP_SCOND);
    misaligned = (addrLow != 2'b00);
    faultNow   = isResvOp && misaligned;
    // Cache-inhibited accesses and cache misses both reach the bus
    toBus      = (opClass != OP_NONE) && !faultNow && (!cacheable || cacheMiss);

    strobes.loadResv  = (opClass == OP_LRES) && !misaligned;
    strobes.scTry     = (opClass == OP_SCOND) && !misaligned;
    strobes.alignErr  = faultNow;
    strobes.extCancel = !cancelAN || !cancelBN;
    strobes.busReq    = toBus;
    // Cacheable storage assumes a single master: a cacheable miss goes out without the attribute
    strobes.busAttr   = toBus && isResvOp && !cacheable;
  end

endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobes,
  input  logic [ADDR_W-3:0] effWord,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic              snoopFromComm,
  input  logic [ADDR_W-3:0] snoopWord,
  output logic              alignFault,
  output logic              scDone,
  output logic              scSuccess,
  output logic              busReq,
  output logic              busResvAttr
);

  localparam int WORD_W = ADDR_W - 2;

  logic              resvValid;
  logic [WORD_W-1:0] resvWord;
  logic              snoopHit;
  logic              dropNow;
  logic              passNow;

  always_comb begin
    snoopHit = resvValid && snoopValid && snoopWrite && snoopFromComm
               && (snoopWord == resvWord);
    dropNow  = strobes.extCancel || snoopHit;
    // A cancel or snoop hit in the same cycle makes the store fail
    passNow  = strobes.scTry && resvValid && (effWord == resvWord) && !dropNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resvValid <= 1'b0;
      resvWord  <= '0;
    end else if (strobes.loadResv) begin
      // A new reservation takes priority over a cancel in the same cycle
      resvValid <= 1'b1;
      resvWord  <= effWord;
    end else if (strobes.scTry || dropNow) begin
      resvValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alignFault  <= 1'b0;
      scDone      <= 1'b0;
      scSuccess   <= 1'b0;
      busReq      <= 1'b0;
      busResvAttr <= 1'b0;
    end else begin
      alignFault  <= strobes.alignErr;
      scDone      <= strobes.scTry;
      scSuccess   <= passNow;
      busReq      <= strobes.busReq;
      busResvAttr <= strobes.busAttr;
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        opClass,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic              cacheable,
  input  logic              cacheMiss,
  input  logic              cancelAN,
  input  logic              cancelBN,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic              snoopFromComm,
  input  logic [ADDR_W-3:0] snoopWord,
  output logic              alignFault,
  output logic              scDone,
  output logic              scSuccess,
  output logic              busReq,
  output logic              busResvAttr
);

  ctrlStrobe_t strobes;

  resv_ctrl ctrl_i (
    .opClass   (opClass_e'(opClass)),
    .addrLow   (effAddr[1:0]),
    .cacheable (cacheable),
    .cacheMiss (cacheMiss),
    .cancelAN  (cancelAN),
    .cancelBN  (cancelBN),
    .strobes   (strobes)
  );

  resv_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .effWord       (effAddr[ADDR_W-1:2]),
    .snoopValid    (snoopValid),
    .snoopWrite    (snoopWrite),
    .snoopFromComm (snoopFromComm),
    .snoopWord     (snoopWord),
    .alignFault    (alignFault),
    .scDone        (scDone),
    .scSuccess     (scSuccess),
    .busReq        (busReq),
    .busResvAttr   (busResvAttr)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] opClass,
  input logic [1:0] addrLow,
  input logic       cacheable,
  input logic       cancelAN,
  input logic       cancelBN,
  input logic       alignFault,
  input logic       scDone,
  input logic       scSuccess,
  input logic       busReq,
  input logic       busResvAttr
);

  p_align_fault_r1: assert property (@(posedge clk) disable iff (rst)
    (opClass[1] && addrLow != 2'b00) |=> (alignFault && !scDone && !busReq));

  p_success_needs_done_r3: assert property (@(posedge clk) disable iff (rst)
    scSuccess |-> scDone);

  p_single_success_r4: assert property (@(posedge clk) disable iff (rst)
    scSuccess |=> !scSuccess);

  p_cancel_fails_store_r7: assert property (@(posedge clk) disable iff (rst)
    (opClass == 2'd3 && addrLow == 2'b00 && (!cancelAN || !cancelBN))
      |=> (scDone && !scSuccess));

  p_cacheable_no_attr_r8: assert property (@(posedge clk) disable iff (rst)
    (opClass[1] && cacheable) |=> !busResvAttr);

  p_attr_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
    busResvAttr |-> busReq);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !(alignFault || scDone || scSuccess || busReq || busResvAttr));

  p_plain_no_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (!opClass[1]) |=> (!alignFault && !scDone));

endmodule

bind resv_monitor resv_monitor_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .opClass     (opClass),
  .addrLow     (effAddr[1:0]),
  .cacheable   (cacheable),
  .cancelAN    (cancelAN),
  .cancelBN    (cancelBN),
  .alignFault  (alignFault),
  .scDone      (scDone),
  .scSuccess   (scSuccess),
  .busReq      (busReq),
  .busResvAttr (busResvAttr)
);

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    opClass = 2'd0;
  logic [AW-1:0] effAddr = '0;
  logic          cacheable = 1'b1;
  logic          cacheMiss = 1'b0;
  logic          cancelAN = 1'b1;
  logic          cancelBN = 1'b1;
  logic          snoopValid = 1'b0;
  logic          snoopWrite = 1'b0;
  logic          snoopFromComm = 1'b0;
  logic [AW-3:0] snoopWord = '0;
  logic          alignFault, scDone, scSuccess, busReq, busResvAttr;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .opClass(opClass), .effAddr(effAddr),
    .cacheable(cacheable), .cacheMiss(cacheMiss),
    .cancelAN(cancelAN), .cancelBN(cancelBN),
    .snoopValid(snoopValid), .snoopWrite(snoopWrite),
    .snoopFromComm(snoopFromComm), .snoopWord(snoopWord),
    .alignFault(alignFault), .scDone(scDone), .scSuccess(scSuccess),
    .busReq(busReq), .busResvAttr(busResvAttr)
  );

  typedef struct {
    logic [4:0] vals;   // {alignFault, scDone, scSuccess, busReq, busResvAttr}
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  // Requirement-level model of the reservation
  bit            mValid = 0;
  logic [AW-3:0] mWord = '0;

  task automatic rstCycle(input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1'b1; opClass = 2'd0; cancelAN = 1'b1; cancelBN = 1'b1; snoopValid = 1'b0;
    mValid = 0;
    e.vals = 5'b0; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drive(input logic [1:0] op, input logic [AW-1:0] addr,
                       input bit cch, input bit miss, input bit cA, input bit cB,
                       input bit sv, input bit sw, input bit sc, input logic [AW-1:0] sAddr,
                       input string tag);
    exp_t e;
    bit mis, resvOp, done, hit, drop, succ, breq, battr, al;
    @(negedge clk);
    rst = 1'b0; opClass = op; effAddr = addr; cacheable = cch; cacheMiss = miss;
    cancelAN = cA; cancelBN = cB; snoopValid = sv; snoopWrite = sw;
    snoopFromComm = sc; snoopWord = sAddr[AW-1:2];
    mis    = (addr[1:0] != 2'b00);
    resvOp = (op == 2'd2) || (op == 2'd3);
    al     = resvOp && mis;
    done   = (op == 2'd3) && !mis;
    hit    = mValid && sv && sw && sc && (sAddr[AW-1:2] == mWord);
    drop   = !cA || !cB || hit;
    succ   = done && mValid && (addr[AW-1:2] == mWord) && !drop;
    breq   = (op != 2'd0) && !al && (!cch || miss);
    battr  = breq && resvOp && !cch;
    if (op == 2'd2 && !mis) begin
      mValid = 1; mWord = addr[AW-1:2];
    end else if (done || drop) begin
      mValid = 0;
    end
    e.vals = {al, done, succ, breq, battr}; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Plain operation with no cancel and no snoop
  task automatic op(input logic [1:0] o, input logic [AW-1:0] a, input bit cch,
                    input bit miss, input string tag);
    drive(o, a, cch, miss, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  // Monitor: results are due one edge after the stimulus
  initial begin
    exp_t e;
    logic [4:0] act;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        act = {alignFault, scDone, scSuccess, busReq, busResvAttr};
        checks++;
        if (act !== e.vals) begin
          errors++;
          $display("FAIL %s: {align,done,succ,breq,attr} actual=%b expected=%b",
                   e.tag, act, e.vals);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    rstCycle("R9 reset"); rstCycle("R9 reset"); rstCycle("R9 reset");
    // R3 store-conditional with no reservation
    op(2'd3, 32'h100, 1, 0, "R3 no reservation");
    // R3 pass, then R4 cleared after a pass
    op(2'd2, 32'h100, 1, 0, "R2 load-reserve");
    op(2'd3, 32'h100, 1, 0, "R3 matching store passes");
    op(2'd3, 32'h100, 1, 0, "R4 cleared after pass");
    // R3 mismatch, R4 cleared after a fail
    op(2'd2, 32'h100, 1, 0, "R2 load-reserve");
    op(2'd3, 32'h104, 1, 0, "R3 word mismatch fails");
    op(2'd3, 32'h100, 1, 0, "R4 cleared after fail");
    // R2 replacement
    op(2'd2, 32'h200, 1, 0, "R2 first");
    op(2'd2, 32'h300, 1, 0, "R2 second");
    op(2'd3, 32'h300, 1, 0, "R2 newer wins");
    op(2'd2, 32'h200, 1, 0, "R2 first");
    op(2'd2, 32'h300, 1, 0, "R2 second");
    op(2'd3, 32'h200, 1, 0, "R2 older lost");
    // R1 misaligned operations leave the reservation
    op(2'd2, 32'h400, 1, 0, "R2 load-reserve");
    op(2'd2, 32'h502, 1, 0, "R1 misaligned load-reserve");
    op(2'd3, 32'h401, 0, 0, "R1 misaligned store, no bus");
    op(2'd3, 32'h400, 1, 0, "R1 reservation kept");
    // R5 each cancel pin
    op(2'd2, 32'h600, 1, 0, "R2 load-reserve");
    drive(2'd0, 32'h0, 1, 0, 1'b0, 1'b1, 0, 0, 0, '0, "R5 cancel A");
    op(2'd3, 32'h600, 1, 0, "R5 cancel A cleared");
    op(2'd2, 32'h600, 1, 0, "R2 load-reserve");
    drive(2'd0, 32'h0, 1, 0, 1'b1, 1'b0, 0, 0, 0, '0, "R5 cancel B");
    op(2'd3, 32'h600, 1, 0, "R5 cancel B cleared");
    // R6 snoop misses, then a hit
    op(2'd2, 32'h700, 1, 0, "R2 load-reserve");
    drive(2'd0, 32'h0, 1, 0, 1, 1, 1, 0, 1, 32'h700, "R6 snoop read");
    drive(2'd0, 32'h0, 1, 0, 1, 1, 1, 1, 0, 32'h700, "R6 other master");
    drive(2'd0, 32'h0, 1, 0, 1, 1, 1, 1, 1, 32'h704, "R6 other word");
    op(2'd3, 32'h700, 1, 0, "R6 no hit keeps reservation");
    op(2'd2, 32'h700, 1, 0, "R2 load-reserve");
    drive(2'd0, 32'h0, 1, 0, 1, 1, 1, 1, 1, 32'h702, "R6 snoop hit");
    op(2'd3, 32'h700, 1, 0, "R6 snoop hit cleared");
    // R7 same-cycle collisions
    drive(2'd2, 32'h800, 1, 0, 1'b0, 1'b1, 0, 0, 0, '0, "R7 cancel with load-reserve");
    op(2'd3, 32'h800, 1, 0, "R7 load-reserve won");
    op(2'd2, 32'h800, 1, 0, "R2 load-reserve");
    drive(2'd3, 32'h800, 1, 0, 1, 1, 1, 1, 1, 32'h800, "R7 snoop with store");
    op(2'd2, 32'h800, 1, 0, "R2 load-reserve");
    drive(2'd3, 32'h800, 1, 0, 1'b1, 1'b0, 0, 0, 0, '0, "R7 cancel with store");
    // R8 bus request and attribute
    op(2'd1, 32'h900, 1, 1, "R8 plain cacheable miss");
    op(2'd2, 32'hA00, 0, 0, "R8 inhibited load-reserve");
    op(2'd3, 32'hA00, 0, 0, "R8 inhibited store-conditional");
    op(2'd2, 32'hA00, 1, 1, "R8 cacheable miss no attribute");
    op(2'd2, 32'hA00, 1, 0, "R8 cacheable hit no bus");
    op(2'd1, 32'hB00, 0, 0, "R8 plain inhibited");
    // R10 plain accesses do not touch the reservation
    op(2'd2, 32'hC00, 1, 0, "R2 load-reserve");
    op(2'd1, 32'hC00, 0, 0, "R10 plain to reserved word");
    op(2'd1, 32'hC01, 1, 0, "R10 misaligned plain");
    op(2'd0, 32'hC03, 1, 0, "R10 idle misaligned");
    op(2'd3, 32'hC00, 1, 0, "R10 reservation kept");
    // R9 reset clears the reservation mid-run
    op(2'd2, 32'hD00, 1, 0, "R2 load-reserve");
    rstCycle("R9 mid-run reset");
    op(2'd3, 32'hD00, 1, 0, "R9 reservation cleared");
    op(2'd0, 32'h0, 1, 0, "R10 idle");
    // Drain
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule